// File: doc/BRIEF.md
# Accumulator ALU with Four-Flag Status

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. Each accepted request carries an operation code, the accumulator value, a second operand, the current flag byte and a 3-bit bit index. The block returns an 8-bit result and a new flag byte one clock later. Instruction decode picks the operation and writes the result and flags back to the register file. Decode, the register file, memory access and instruction timing all sit outside this block.

The flag byte holds only four flags, in its upper nibble: zero, subtract, half carry and carry. Its lower nibble always reads as zero. The subtract and half-carry flags carry forward what the decimal-adjust operation needs to correct a packed-BCD sum or difference. The operation set has four groups:

- Accumulator arithmetic and logic.
- Increment and decrement of the operand.
- Flag manipulation.
- An extended group of rotates, shifts, a nibble swap and single-bit test, set and clear.

Top module: `alu8_flags_unit`

## Requirements
- R1: `op_i` encodes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare, 8 increment, 9 decrement, 10 decimal adjust, 11 complement, 12 set carry, 13 complement carry, 14 rotate-acc-left circular, 15 rotate-acc-left via carry, 16 rotate-acc-right circular, 17 rotate-acc-right via carry, 18 rotate-left circular, 19 rotate-left via carry, 20 rotate-right circular, 21 rotate-right via carry, 22 shift left, 23 arithmetic shift right, 24 logical shift right, 25 nibble swap, 26 bit test, 27 bit set, 28 bit clear. A request with `in_valid_i` high at a clock edge produces `out_valid_o` high and its `result_o`/`flags_o` after that edge. Cycles without a request drop `out_valid_o` and leave `result_o` and `flags_o` unchanged.
- R2: `flags_o` bit 7 is zero (Z), bit 6 is subtract (N), bit 5 is half carry (H) and bit 4 is carry (C). Bits 3..0 are always 0, whatever `flags_i[3:0]` holds.
- R3: Add and add-with-carry compute acc + operand (+C). They set Z from the result, clear N, set H on a carry out of bit 3 and set C on a carry out of bit 7.
- R4: Subtract and subtract-with-borrow compute acc - operand (-C). They set N, set H on a borrow from bit 4 and set C on a borrow from bit 8. Compare produces the same flags but returns the accumulator unchanged as its result.
- R5: AND sets H and clears N and C. OR and XOR clear N, H and C. All three set Z from the result.
- R6: Increment and decrement act on the operand and keep C. Increment clears N and sets H when the low nibble was 0xF. Decrement sets N and sets H when the low nibble was 0x0.
- R7: Decimal adjust acts on the accumulator. With N=0 it adds 0x06 if H=1 or the low nibble is above 9, and adds 0x60 and sets C if C=1 or the accumulator is above 0x99. With N=1 it subtracts 0x06 if H=1 and 0x60 if C=1. It then clears H, keeps N and sets Z from the result.
- R8: Complement inverts the accumulator, sets N and H, and keeps Z and C. Set-carry sets C and complement-carry inverts C. Both clear N and H, keep Z and return the accumulator.
- R9: The accumulator rotates (codes 14-17) act on the accumulator. C takes the bit shifted out, and Z, N and H are all forced to 0.
- R10: The extended rotates and shifts (codes 18-24) act on the operand. C takes the bit shifted out, Z comes from the result, and N and H are cleared. The arithmetic right shift keeps bit 7 and the logical right shift feeds in 0.
- R11: Nibble swap exchanges operand bits 7..4 with bits 3..0. Z comes from the result and N, H and C are cleared.
- R12: Bit test sets Z when operand bit `bit_sel_i` is 0, clears N, sets H, keeps C and returns the operand. Bit set and bit clear force that one bit to 1 or 0 and return the flags unchanged.
- R13: While `rst_ni` is low, `out_valid_o`, `result_o` and `flags_o` are 0. Reset is released internally on the second clock edge after `rst_ni` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand / target register value |
| flags_i | input | 8 | Current flag byte |
| bit_sel_i | input | 3 | Bit index for bit test/set/clear |
| out_valid_o | output | 1 | Result strobe, one cycle after the request |
| result_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered flag byte |

## Verification
Each operation is tried with directed values at its edges:

- Wraps to zero that separate a carry out of bit 7 from one out of bit 3.
- Equal and reversed compare operands that show the borrow without a write-back.
- Decimal-adjust inputs covering each correction path for both add and subtract history.
- Rotates of a zero operand, which tell the accumulator variants (Z forced low) from the extended ones (Z from the result).

A sweep of sixteen operand pairs through add and subtract compares against flags recomputed from integer arithmetic. Incoming flag bytes carry junk in the low nibble and preset carry values, to show which flags are kept and which are forced.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int OPW = 5;
  localparam int BSW = $clog2(DW);

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_AND  = 5'd4,  OP_XOR  = 5'd5,  OP_OR   = 5'd6,  OP_CMP  = 5'd7,
    OP_INC  = 5'd8,  OP_DEC  = 5'd9,  OP_DAA  = 5'd10, OP_CPL  = 5'd11,
    OP_SCF  = 5'd12, OP_CCF  = 5'd13,
    OP_RLCA = 5'd14, OP_RLA  = 5'd15, OP_RRCA = 5'd16, OP_RRA  = 5'd17,
    OP_RLC  = 5'd18, OP_RL   = 5'd19, OP_RRC  = 5'd20, OP_RR   = 5'd21,
    OP_SLA  = 5'd22, OP_SRA  = 5'd23, OP_SRL  = 5'd24, OP_SWAP = 5'd25,
    OP_BIT  = 5'd26, OP_SET  = 5'd27, OP_RES  = 5'd28
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flag_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  flag_t         f_i,
  output logic [DW-1:0] r_o,
  output flag_t         f_o,
  output logic          sel_o
);
  logic [DW-1:0] x, y, yy, sum;
  logic [NW-1:0] lo, hi;
  logic          sub, ci, cc, hc, c8, keep_c;

  always_comb begin
    x      = a_i;
    y      = b_i;
    sub    = 1'b0;
    ci     = 1'b0;
    keep_c = 1'b0;
    sel_o  = 1'b1;
    unique case (op_i)
      OP_ADD: ;
      OP_ADC: ci = f_i.c;
      OP_SUB: sub = 1'b1;
      OP_SBC: begin sub = 1'b1; ci = f_i.c; end
      OP_CMP: sub = 1'b1;
      OP_INC: begin x = b_i; y = DW'(1); keep_c = 1'b1; end
      OP_DEC: begin x = b_i; y = DW'(1); keep_c = 1'b1; sub = 1'b1; end
      default: sel_o = 1'b0;
    endcase
  end

  // One adder split at the nibble boundary; subtraction via inverted operand.
  always_comb begin
    yy        = sub ? ~y : y;
    cc        = ci ^ sub;
    {hc, lo}  = {1'b0, x[NW-1:0]} + {1'b0, yy[NW-1:0]} + {{NW{1'b0}}, cc};
    {c8, hi}  = {1'b0, x[DW-1:NW]} + {1'b0, yy[DW-1:NW]} + {{NW{1'b0}}, hc};
    sum       = {hi, lo};
    f_o.z     = (sum == '0);
    f_o.n     = sub;
    f_o.h     = hc ^ sub;
    f_o.c     = keep_c ? f_i.c : (c8 ^ sub);
    r_o       = (op_i == OP_CMP) ? a_i : sum;
  end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  flag_t         f_i,
  output logic [DW-1:0] r_o,
  output flag_t         f_o
);
  localparam logic [DW-1:0] LoFix = DW'(8'h06);
  localparam logic [DW-1:0] HiFix = DW'(8'h60);
  localparam logic [DW-1:0] BcdMax = DW'(8'h99);
  localparam logic [NW-1:0] DigMax = NW'(9);

  logic [DW-1:0] corr;
  logic          c_new;

  always_comb begin
    corr  = '0;
    c_new = f_i.c;
    if (!f_i.n) begin
      if (f_i.h || (a_i[NW-1:0] > DigMax)) corr = corr | LoFix;
      if (f_i.c || (a_i > BcdMax)) begin
        corr  = corr | HiFix;
        c_new = 1'b1;
      end
      r_o = a_i + corr;
    end else begin
      if (f_i.h) corr = corr | LoFix;
      if (f_i.c) corr = corr | HiFix;
      r_o = a_i - corr;
    end
    f_o.z = (r_o == '0);
    f_o.n = f_i.n;
    f_o.h = 1'b0;
    f_o.c = c_new;
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  flag_t         f_i,
  output logic [DW-1:0] r_o,
  output flag_t         f_o,
  output logic          sel_o
);
  always_comb begin
    sel_o = 1'b1;
    r_o   = a_i;
    f_o   = f_i;
    unique case (op_i)
      OP_AND: begin r_o = a_i & b_i; f_o = '{z: (r_o == '0), n: 1'b0, h: 1'b1, c: 1'b0}; end
      OP_OR:  begin r_o = a_i | b_i; f_o = '{z: (r_o == '0), n: 1'b0, h: 1'b0, c: 1'b0}; end
      OP_XOR: begin r_o = a_i ^ b_i; f_o = '{z: (r_o == '0), n: 1'b0, h: 1'b0, c: 1'b0}; end
      OP_CPL: begin r_o = ~a_i; f_o.n = 1'b1; f_o.h = 1'b1; end
      OP_SCF: begin f_o.n = 1'b0; f_o.h = 1'b0; f_o.c = 1'b1; end
      OP_CCF: begin f_o.n = 1'b0; f_o.h = 1'b0; f_o.c = ~f_i.c; end
      default: sel_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
(
  input  alu_op_e        op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [BSW-1:0] bit_sel_i,
  input  flag_t          f_i,
  output logic [DW-1:0]  r_o,
  output flag_t          f_o,
  output logic           sel_o
);
  logic [DW-1:0] mask, src;
  logic          acc_form;

  // One-hot bit mask for test/set/clear.
  for (genvar g = 0; g < DW; g++) begin : g_mask
    assign mask[g] = (bit_sel_i == BSW'(g));
  end

  assign acc_form = (op_i == OP_RLCA) || (op_i == OP_RLA) ||
                    (op_i == OP_RRCA) || (op_i == OP_RRA);
  assign src      = acc_form ? a_i : b_i;

  always_comb begin
    sel_o = 1'b1;
    r_o   = src;
    f_o   = f_i;
    unique case (op_i)
      OP_RLCA, OP_RLC: begin r_o = {src[DW-2:0], src[DW-1]}; f_o.c = src[DW-1]; end
      OP_RLA,  OP_RL:  begin r_o = {src[DW-2:0], f_i.c};     f_o.c = src[DW-1]; end
      OP_RRCA, OP_RRC: begin r_o = {src[0], src[DW-1:1]};    f_o.c = src[0];    end
      OP_RRA,  OP_RR:  begin r_o = {f_i.c, src[DW-1:1]};     f_o.c = src[0];    end
      OP_SLA:          begin r_o = {src[DW-2:0], 1'b0};      f_o.c = src[DW-1]; end
      OP_SRA:          begin r_o = {src[DW-1], src[DW-1:1]}; f_o.c = src[0];    end
      OP_SRL:          begin r_o = {1'b0, src[DW-1:1]};      f_o.c = src[0];    end
      OP_SWAP:         begin r_o = {src[NW-1:0], src[DW-1:NW]}; f_o.c = 1'b0;   end
      OP_BIT:          begin f_o.z = ~|(src & mask); f_o.n = 1'b0; f_o.h = 1'b1; end
      OP_SET:          r_o = src | mask;
      OP_RES:          r_o = src & ~mask;
      default:         sel_o = 1'b0;
    endcase
    if (sel_o && (op_i != OP_BIT) && (op_i != OP_SET) && (op_i != OP_RES)) begin
      f_o.n = 1'b0;
      f_o.h = 1'b0;
      f_o.z = acc_form ? 1'b0 : (r_o == '0);
    end
  end
endmodule

// File: rtl/alu8_flags_unit.sv
module alu8_flags_unit
  import alu8_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  opnd_i,
  input  logic [DW-1:0]  flags_i,
  input  logic [BSW-1:0] bit_sel_i,
  output logic           out_valid_o,
  output logic [DW-1:0]  result_o,
  output logic [DW-1:0]  flags_o
);
  localparam int LowW = DW - 4;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  alu_op_e       op;
  flag_t         f_in;
  logic          unused_flag_lo;

  assign op             = alu_op_e'(op_i);
  assign f_in           = flag_t'(flags_i[DW-1:LowW]);
  assign unused_flag_lo = ^flags_i[LowW-1:0];

  logic [DW-1:0] ar_r, bc_r, lg_r, sh_r;
  flag_t         ar_f, bc_f, lg_f, sh_f;
  logic          ar_sel, lg_sel, sh_sel;

  alu8_arith u_arith (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .f_i(f_in),
    .r_o(ar_r), .f_o(ar_f), .sel_o(ar_sel)
  );

  alu8_bcd u_bcd (
    .a_i(acc_i), .f_i(f_in), .r_o(bc_r), .f_o(bc_f)
  );

  alu8_logic u_logic (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .f_i(f_in),
    .r_o(lg_r), .f_o(lg_f), .sel_o(lg_sel)
  );

  alu8_shift u_shift (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .bit_sel_i(bit_sel_i), .f_i(f_in),
    .r_o(sh_r), .f_o(sh_f), .sel_o(sh_sel)
  );

  logic [DW-1:0] op_r;
  flag_t         op_f;

  always_comb begin
    op_r = acc_i;
    op_f = f_in;
    if (ar_sel) begin
      op_r = ar_r; op_f = ar_f;
    end else if (op == OP_DAA) begin
      op_r = bc_r; op_f = bc_f;
    end else if (lg_sel) begin
      op_r = lg_r; op_f = lg_f;
    end else if (sh_sel) begin
      op_r = sh_r; op_f = sh_f;
    end
  end

  // Next-state and register processes.
  logic          vld_q, vld_d;
  logic [DW-1:0] res_q, res_d;
  flag_t         flg_q, flg_d;

  always_comb begin
    vld_d = in_valid_i;
    res_d = res_q;
    flg_d = flg_q;
    if (in_valid_i) begin
      res_d = op_r;
      flg_d = op_f;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign out_valid_o = vld_q;
  assign result_o    = res_q;
  assign flags_o     = {flg_q, {LowW{1'b0}}};
endmodule

// File: rtl/alu8_flags_unit_chk.sv
module alu8_flags_unit_chk
  import alu8_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           in_valid_i,
  input logic [OPW-1:0] op_i,
  input logic [DW-1:0]  acc_i,
  input logic [DW-1:0]  flags_i,
  input logic           out_valid_o,
  input logic [DW-1:0]  result_o,
  input logic [DW-1:0]  flags_o
);
  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  assert_idle_drops_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(result_o) && $stable(flags_o)));

  assert_low_nibble_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[3:0] == 4'b0000);

  assert_cmp_keeps_acc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_CMP) |=> (result_o == $past(acc_i) && flags_o[6]));

  assert_incdec_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flags_o[4] == $past(flags_i[4])));

  assert_acc_rot_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i >= OP_RLCA && op_i <= OP_RRA) |=> (flags_o[7:5] == 3'b000));

  assert_setres_flags_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (op_i == OP_SET || op_i == OP_RES)) |=> (flags_o[7:4] == $past(flags_i[7:4])));
endmodule

bind alu8_flags_unit alu8_flags_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_sync_n), .in_valid_i(in_valid_i), .op_i(op_i),
  .acc_i(acc_i), .flags_i(flags_i), .out_valid_o(out_valid_o),
  .result_o(result_o), .flags_o(flags_o)
);

// File: tb/alu8_flags_unit_test.sv
`timescale 1ns/1ps
module alu8_flags_unit_test;
  import alu8_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] acc = '0, opnd = '0, flags = '0;
  logic [2:0] bsel = '0;
  logic       out_valid;
  logic [7:0] result, flags_out;

  always #2.5 clk = ~clk;

  alu8_flags_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_i(op),
    .acc_i(acc), .opnd_i(opnd), .flags_i(flags), .bit_sel_i(bsel),
    .out_valid_o(out_valid), .result_o(result), .flags_o(flags_out)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] q_r[$], q_f[$];
  string      q_t[$];

  task automatic check(string tag, bit ok, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(alu_op_e o, logic [7:0] a, logic [7:0] b, logic [7:0] f,
                      logic [2:0] n, logic [7:0] er, logic [7:0] ef, string tag);
    @(negedge clk);
    in_valid = 1'b1; op = o; acc = a; opnd = b; flags = f; bsel = n;
    q_r.push_back(er); q_f.push_back(ef); q_t.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_r.size() == 0) begin
        check("R1 unexpected out_valid", 1'b0, 16'h1, 16'h0);
      end else begin
        automatic logic [7:0] er = q_r.pop_front();
        automatic logic [7:0] ef = q_f.pop_front();
        automatic string      t  = q_t.pop_front();
        check(t, {result, flags_out} === {er, ef}, {result, flags_out}, {er, ef});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] hold_r, hold_f;
    repeat (3) @(negedge clk);
    check("R13 reset state", {out_valid, result, flags_out} === 17'h0,
          {7'h0, out_valid, result}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 add / add with carry
    send(OP_ADD, 8'hFF, 8'h01, 8'h00, 0, 8'h00, 8'hB0, "R3 add wrap");
    send(OP_ADC, 8'h0E, 8'h01, 8'h10, 0, 8'h10, 8'h20, "R3 adc half");
    // R2 junk low nibble
    send(OP_ADD, 8'h01, 8'h01, 8'h0F, 0, 8'h02, 8'h00, "R2 low nibble zero");
    // R4 subtract family
    send(OP_SUB, 8'h10, 8'h01, 8'h00, 0, 8'h0F, 8'h60, "R4 sub half borrow");
    send(OP_SBC, 8'h00, 8'h00, 8'h10, 0, 8'hFF, 8'h70, "R4 sbc borrow");
    send(OP_CMP, 8'h42, 8'h42, 8'h00, 0, 8'h42, 8'hC0, "R4 cmp equal");
    send(OP_CMP, 8'h10, 8'h20, 8'h00, 0, 8'h10, 8'h50, "R4 cmp less");
    // R5 logic
    send(OP_AND, 8'hF0, 8'h0F, 8'h10, 0, 8'h00, 8'hA0, "R5 and zero");
    send(OP_XOR, 8'h55, 8'h55, 8'hF0, 0, 8'h00, 8'h80, "R5 xor zero");
    send(OP_OR,  8'h00, 8'h81, 8'hB0, 0, 8'h81, 8'h00, "R5 or");
    // R6 inc / dec
    send(OP_INC, 8'h33, 8'hFF, 8'h10, 0, 8'h00, 8'hB0, "R6 inc wrap keep C");
    send(OP_INC, 8'h00, 8'h0F, 8'h00, 0, 8'h10, 8'h20, "R6 inc half");
    send(OP_DEC, 8'h00, 8'h01, 8'h00, 0, 8'h00, 8'hC0, "R6 dec to zero");
    send(OP_DEC, 8'h00, 8'h00, 8'h10, 0, 8'hFF, 8'h70, "R6 dec borrow keep C");
    // R7 decimal adjust
    send(OP_DAA, 8'h7D, 8'h00, 8'h00, 0, 8'h83, 8'h00, "R7 daa low fix");
    send(OP_DAA, 8'h9A, 8'h00, 8'h00, 0, 8'h00, 8'h90, "R7 daa both fix");
    send(OP_DAA, 8'h0F, 8'h00, 8'h60, 0, 8'h09, 8'h40, "R7 daa sub half");
    send(OP_DAA, 8'hE0, 8'h00, 8'h50, 0, 8'h80, 8'h50, "R7 daa sub carry");
    // R8 complement and carry ops
    send(OP_CPL, 8'h35, 8'h00, 8'h80, 0, 8'hCA, 8'hE0, "R8 cpl");
    send(OP_SCF, 8'h12, 8'h00, 8'hE0, 0, 8'h12, 8'h90, "R8 scf");
    send(OP_CCF, 8'h12, 8'h00, 8'h70, 0, 8'h12, 8'h00, "R8 ccf");
    // R9 accumulator rotates
    send(OP_RLCA, 8'h80, 8'h00, 8'h00, 0, 8'h01, 8'h10, "R9 rlca");
    send(OP_RLCA, 8'h00, 8'h00, 8'h80, 0, 8'h00, 8'h00, "R9 rlca zero forced");
    send(OP_RLA,  8'h80, 8'h00, 8'h00, 0, 8'h00, 8'h10, "R9 rla");
    send(OP_RRCA, 8'h01, 8'h00, 8'h00, 0, 8'h80, 8'h10, "R9 rrca");
    send(OP_RRA,  8'h01, 8'h00, 8'h10, 0, 8'h80, 8'h10, "R9 rra");
    // R10 extended rotates and shifts
    send(OP_RLC, 8'h55, 8'h00, 8'h00, 0, 8'h00, 8'h80, "R10 rlc zero");
    send(OP_RL,  8'h55, 8'h80, 8'h00, 0, 8'h00, 8'h90, "R10 rl");
    send(OP_RRC, 8'h55, 8'h02, 8'h10, 0, 8'h01, 8'h00, "R10 rrc");
    send(OP_RR,  8'h55, 8'h01, 8'h10, 0, 8'h80, 8'h10, "R10 rr");
    send(OP_SLA, 8'h55, 8'hFF, 8'h00, 0, 8'hFE, 8'h10, "R10 sla");
    send(OP_SRA, 8'h55, 8'h81, 8'h00, 0, 8'hC0, 8'h10, "R10 sra keeps msb");
    send(OP_SRL, 8'h55, 8'h01, 8'h00, 0, 8'h00, 8'h90, "R10 srl");
    // R11 swap
    send(OP_SWAP, 8'h00, 8'hA5, 8'h70, 0, 8'h5A, 8'h00, "R11 swap");
    send(OP_SWAP, 8'h11, 8'h00, 8'h70, 0, 8'h00, 8'h80, "R11 swap zero");
    // R12 bit ops
    send(OP_BIT, 8'h00, 8'h7F, 8'h10, 7, 8'h7F, 8'hB0, "R12 bit clear");
    send(OP_BIT, 8'h00, 8'h01, 8'h40, 0, 8'h01, 8'h20, "R12 bit set");
    send(OP_SET, 8'h00, 8'h00, 8'h50, 3, 8'h08, 8'h50, "R12 set");
    send(OP_RES, 8'h00, 8'hFF, 8'hA0, 0, 8'hFE, 8'hA0, "R12 res");

    // R3/R4 sweep with integer-derived flags
    for (int i = 0; i < 16; i++) begin
      automatic int a = (i * 37 + 5) & 255;
      automatic int b = (i * 91 + 3) & 255;
      automatic int s = a + b;
      automatic int d = a - b;
      automatic logic [7:0] fs, fd;
      fs = {(s & 255) == 0, 1'b0, ((a & 15) + (b & 15)) > 15, s > 255, 4'b0};
      fd = {(d & 255) == 0, 1'b1, (a & 15) < (b & 15), a < b, 4'b0};
      send(OP_ADD, 8'(a), 8'(b), 8'h00, 0, 8'(s), fs, "R3 add sweep");
      send(OP_SUB, 8'(a), 8'(b), 8'h00, 0, 8'(d), fd, "R4 sub sweep");
    end

    // R1 hold when idle
    idle(2);
    hold_r = result; hold_f = flags_out;
    flags = 8'hFF; acc = 8'h77; opnd = 8'h66; op = OP_ADD;
    idle(3);
    check("R1 idle valid low", out_valid === 1'b0, {15'h0, out_valid}, 16'h0);
    check("R1 idle hold", {result, flags_out} === {hold_r, hold_f},
          {result, flags_out}, {hold_r, hold_f});
    check("R1 scoreboard drained", q_r.size() == 0, 16'(q_r.size()), 16'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule